// File: doc/BRIEF.md
# NAND Command Queue Sequencer

This block drives a raw 8-bit NAND flash bus from 32-bit command words that software writes into a small command FIFO. A fetch stage holds the next word in a one-entry request register, and an execute stage turns it into bus activity. That activity is a command-latch byte, an address-latch byte, a programmable idle delay, or a wait for the ready/busy pin with a timeout. Consecutive words run back to back with no dead clock between them.

Software sees three registers on a simple synchronous register port, selected by `reg_addr`. Register 0 is the command port. A write with bit 31 clear pushes a word. A write with bit 31 set makes the programmed bus cycle length take effect. A read returns the FIFO occupancy. Register 1 holds the configuration, and register 2 holds two sticky status flags. A ready/busy wait can raise an interrupt on completion. Software acknowledges that interrupt by clearing the interrupt enable. Data transfers are not carried out. Words that request them are consumed as no-ops.

Top module: `nandq_sequencer`

## Requirements
- R1: After reset the pins are idle: `ce_n_o`=4'hF, `cle_o`=0, `ale_o`=0, `we_n_o`=1, `re_n_o`=1, `dq_oe_o`=0 and `irq_o`=0. The registers read 0 (occupancy), 0x00000005 (configuration) and 0 (status).
- R2: A write to register 0 with bit 31 clear pushes the word when the FIFO holds fewer than FIFO_DEPTH words. Register 0 reads the occupancy in bits [26:22]. A push to a full FIFO is dropped and sets status bit 0. Writing 1 to that bit clears it.
- R3: A word whose bits [17:14] are 0x5, with bits 21 and 20 clear, runs one bus cycle of L clocks. During that cycle `cle_o`=1 and `dq_o` carries bits [7:0]. `we_n_o` is low for the first floor(L/2) clocks, and the latch and the data are stable when `we_n_o` rises.
- R4: The code 0x6 in bits [17:14] does the same as R3 but with `ale_o` high instead of `cle_o`.
- R5: The bus cycle length is L = field+1, where the field is configuration bits [4:0]; a field of 0 gives L=2. A new field takes effect only after a register 0 write with bit 31 set. The default L is 6.
- R6: The code 0xC in bits [17:14] idles for N*L clocks, where N is bits [9:0]. When N=0 it takes exactly one clock.
- R7: A word with bit 20 set (and bit 21 clear) waits until the synchronised R/B# input is high. If R/B# stays low for 2^E bus cycles, where E is bits [4:0], the wait ends and status bit 1 is set. A successful wait leaves status bit 1 unchanged.
- R8: When a ready/busy wait with bit 14 set ends while configuration bit 21 is 1, `irq_o` rises and stays high until configuration bit 21 is written 0. Without bit 14, or with the enable at 0 at completion, no interrupt is raised.
- R9: The occupancy excludes the word in the request stage and the word executing. After a run of bus words followed by two idle words, the occupancy reads 0 only once every earlier bus word has finished.
- R10: Words with bit 21 set, and words with an unlisted code in bits [17:14], take one clock, make no bus strobe and leave the chip enables unchanged.
- R11: Words execute in the order they were pushed, and consecutive bus bytes start exactly L clocks apart.
- R12: Bits [13:10] of each byte, idle or ready/busy word drive `ce_n_o`, which holds that value until a later such word replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 command, 1 configuration, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ce_n_o | output | 4 | Active-low chip enables |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Active-low write strobe |
| re_n_o | output | 1 | Active-low read strobe (held high) |
| dq_o | output | 8 | Flash data bus output |
| dq_oe_o | output | 1 | Data bus output enable |
| rb_n_i | input | 1 | Ready/busy pin, low when busy |
| irq_o | output | 1 | Ready/busy completion interrupt |

## Verification
The hardest state to reach from the ports is a FIFO overflow that happens while two words already sit outside the FIFO, one in the request stage and one executing. The stimulus first pushes two long idle words back to back so that they fill both pipeline slots. It then pushes nine short words in consecutive clocks. The bench works out clock by clock that eight words land and the ninth is dropped. The drain rule is reached the same way, by polling occupancy each clock after a tail of two idle words and comparing it with the number of write strobes already seen on the bus.

// File: rtl/nq_pkg.sv
package nq_pkg;

  typedef enum logic [2:0] {
    K_NOP,
    K_IDLE,
    K_CLE,
    K_ALE,
    K_RBW
  } nq_kind_e;

  typedef struct packed {
    nq_kind_e    kind;
    logic [3:0]  ce_n;
    logic [9:0]  arg;
    logic        irq_req;
  } nq_op_t;

  localparam int unsigned TYPE_LO  = 14;
  localparam int unsigned CE_LO    = 10;
  localparam int unsigned RB_BIT   = 20;
  localparam int unsigned MOVE_BIT = 21;
  localparam int unsigned APPLY_BIT = 31;
  localparam int unsigned IRQEN_BIT = 21;
  localparam int unsigned OCC_LO   = 22;

  // Classify one command word.
  function automatic nq_op_t nq_decode(input logic [31:0] w);
    nq_op_t o;
    o.ce_n    = w[CE_LO +: 4];
    o.arg     = w[9:0];
    o.irq_req = w[TYPE_LO];
    if (w[MOVE_BIT])      o.kind = K_NOP;
    else if (w[RB_BIT])   o.kind = K_RBW;
    else begin
      case (w[TYPE_LO +: 4])
        4'hC:    o.kind = K_IDLE;
        4'h5:    o.kind = K_CLE;
        4'h6:    o.kind = K_ALE;
        default: o.kind = K_NOP;
      endcase
    end
    return o;
  endfunction

  // Bus cycle length in clocks from the configuration field (minimum 2).
  function automatic logic [5:0] nq_cycle_len(input logic [4:0] f);
    return (f == 5'd0) ? 6'd2 : ({1'b0, f} + 6'd1);
  endfunction

  // Clocks that the write strobe stays low inside one bus cycle.
  function automatic logic [5:0] nq_we_low(input logic [5:0] len);
    return len >> 1;
  endfunction

  // Last bus-cycle index of a ready/busy wait of 2^e bus cycles.
  function automatic logic [31:0] nq_rb_last(input logic [4:0] e);
    return (32'd1 << e) - 32'd1;
  endfunction

endpackage

// File: rtl/nq_cmd_fifo.sv
module nq_cmd_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R2
  fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

endmodule

// File: rtl/nq_exec.sv
module nq_exec
  import nq_pkg::*;
#(
  parameter int unsigned TMO_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] word,
  input  logic [4:0]  cyc_field,
  input  logic        rb_hi,
  output logic        ready,
  output logic [3:0]  ce_n_o,
  output logic        cle_o,
  output logic        ale_o,
  output logic        we_n_o,
  output logic [7:0]  dq_o,
  output logic        dq_oe_o,
  output logic        ev_rb_end,
  output logic        ev_rb_tmo,
  output logic        rb_irq_req
);

  typedef enum logic [1:0] {S_IDLE, S_BYTE, S_WAIT, S_RB} st_e;

  st_e              st;
  logic [5:0]       clk_cnt;
  logic [9:0]       rem;
  logic [TMO_W-1:0] tmo_cnt;
  logic [4:0]       rb_exp;
  logic             cur_irq;
  logic [3:0]       ce_q;
  logic [7:0]       dq_q;
  logic             is_cle;

  nq_op_t     op;
  logic [5:0] len;
  logic       last_clk;
  logic       tmo_hit;
  logic       done;

  assign op       = nq_decode(word);
  assign len      = nq_cycle_len(cyc_field);
  assign last_clk = (clk_cnt >= len - 6'd1);
  assign tmo_hit  = last_clk && (tmo_cnt == TMO_W'(nq_rb_last(rb_exp)));

  always_comb begin
    case (st)
      S_BYTE:  done = last_clk;
      S_WAIT:  done = (rem == '0) || ((rem == 10'd1) && last_clk);
      S_RB:    done = rb_hi || tmo_hit;
      default: done = 1'b0;
    endcase
  end

  assign ready      = (st == S_IDLE) || done;
  assign ev_rb_end  = (st == S_RB) && done;
  assign ev_rb_tmo  = (st == S_RB) && !rb_hi && tmo_hit;
  assign rb_irq_req = cur_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      clk_cnt <= '0;
      rem     <= '0;
      tmo_cnt <= '0;
      rb_exp  <= '0;
      cur_irq <= 1'b0;
      ce_q    <= 4'hF;
      dq_q    <= '0;
      is_cle  <= 1'b0;
    end else if (start) begin
      clk_cnt <= '0;
      tmo_cnt <= '0;
      rem     <= op.arg;
      rb_exp  <= op.arg[4:0];
      cur_irq <= op.irq_req;
      if (op.kind != K_NOP) ce_q <= op.ce_n;
      case (op.kind)
        K_CLE, K_ALE: begin
          st     <= S_BYTE;
          dq_q   <= op.arg[7:0];
          is_cle <= (op.kind == K_CLE);
        end
        K_RBW:   st <= S_RB;
        K_IDLE:  st <= S_WAIT;
        default: begin
          st  <= S_WAIT;
          rem <= '0;
        end
      endcase
    end else if (done) begin
      st <= S_IDLE;
    end else if (st != S_IDLE) begin
      clk_cnt <= last_clk ? '0 : clk_cnt + 6'd1;
      if (last_clk && st == S_WAIT) rem <= rem - 10'd1;
      if (last_clk && st == S_RB)   tmo_cnt <= tmo_cnt + TMO_W'(1);
    end
  end

  assign ce_n_o  = ce_q;
  assign cle_o   = (st == S_BYTE) && is_cle;
  assign ale_o   = (st == S_BYTE) && !is_cle;
  assign we_n_o  = !((st == S_BYTE) && (clk_cnt < nq_we_low(len)));
  assign dq_o    = dq_q;
  assign dq_oe_o = (st == S_BYTE);

  // R3
  we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n_o && !$past(we_n_o)) |-> ((cle_o || ale_o) && $stable(dq_o)));

  // R12
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE) && $past(st == S_IDLE)) |-> $stable(ce_n_o));

  // R7
  rb_tmo_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rb_tmo |-> !rb_hi);

endmodule

// File: rtl/nandq_sequencer.sv
module nandq_sequencer
  import nq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,   // at most 31 so occupancy fits its field
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMO_W = 32,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [3:0]  ce_n_o,
  output logic        cle_o,
  output logic        ale_o,
  output logic        we_n_o,
  output logic        re_n_o,
  output logic [7:0]  dq_o,
  output logic        dq_oe_o,
  input  logic        rb_n_i,
  output logic        irq_o
);

  logic [31:0] cfg_q;
  logic [4:0]  cyc_act;
  logic        ovf_q, tmo_q, irq_q;

  logic        wr_cmd, wr_cfg, wr_stat;
  logic        push_req, apply_req, push_drop;
  logic        stat_clr_ovf, stat_clr_tmo;

  logic [31:0] fifo_dout;
  logic [CW-1:0] fifo_count;
  logic        fifo_full, fifo_empty;

  logic        req_valid;
  logic [31:0] req_word;
  logic        req_load, exec_take, exec_ready;

  logic        ev_rb_end, ev_rb_tmo, rb_irq_req, irq_fire;
  logic [SYNC_STAGES-1:0] rb_sync;

  assign wr_cmd       = reg_wr && (reg_addr == 2'd0);
  assign wr_cfg       = reg_wr && (reg_addr == 2'd1);
  assign wr_stat      = reg_wr && (reg_addr == 2'd2);
  assign apply_req    = wr_cmd && reg_wdata[APPLY_BIT];
  assign push_req     = wr_cmd && !reg_wdata[APPLY_BIT];
  assign push_drop    = push_req && fifo_full;
  assign stat_clr_ovf = wr_stat && reg_wdata[0];
  assign stat_clr_tmo = wr_stat && reg_wdata[1];

  nq_cmd_fifo #(
    .DEPTH (FIFO_DEPTH),
    .WIDTH (32)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_req),
    .pop   (req_load),
    .din   (reg_wdata),
    .dout  (fifo_dout),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  // Fetch stage: one request slot between the FIFO and the executor.
  assign exec_take = req_valid && exec_ready;
  assign req_load  = !fifo_empty && (!req_valid || exec_take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_word  <= '0;
    end else if (req_load) begin
      req_valid <= 1'b1;
      req_word  <= fifo_dout;
    end else if (exec_take) begin
      req_valid <= 1'b0;
    end
  end

  // Ready/busy synchroniser, reset to the ready level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_sync <= '1;
    else        rb_sync <= {rb_sync[SYNC_STAGES-2:0], rb_n_i};
  end

  nq_exec #(
    .TMO_W (TMO_W)
  ) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (exec_take),
    .word       (req_word),
    .cyc_field  (cyc_act),
    .rb_hi      (rb_sync[SYNC_STAGES-1]),
    .ready      (exec_ready),
    .ce_n_o     (ce_n_o),
    .cle_o      (cle_o),
    .ale_o      (ale_o),
    .we_n_o     (we_n_o),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o),
    .ev_rb_end  (ev_rb_end),
    .ev_rb_tmo  (ev_rb_tmo),
    .rb_irq_req (rb_irq_req)
  );

  assign irq_fire = ev_rb_end && rb_irq_req && cfg_q[IRQEN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 32'h0000_0005;
      cyc_act <= 5'd5;
      ovf_q   <= 1'b0;
      tmo_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_cfg)    cfg_q   <= reg_wdata;
      if (apply_req) cyc_act <= cfg_q[4:0];
      if (push_drop)         ovf_q <= 1'b1;
      else if (stat_clr_ovf) ovf_q <= 1'b0;
      if (ev_rb_tmo)         tmo_q <= 1'b1;
      else if (stat_clr_tmo) tmo_q <= 1'b0;
      if (wr_cfg && !reg_wdata[IRQEN_BIT]) irq_q <= 1'b0;
      else if (irq_fire)                   irq_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0: begin
        reg_rdata = '0;
        reg_rdata[OCC_LO +: 5] = 5'(fifo_count);
      end
      2'd1:    reg_rdata = cfg_q;
      2'd2:    reg_rdata = {30'd0, tmo_q, ovf_q};
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o  = irq_q;
  assign re_n_o = 1'b1;

  // R8
  irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cfg_q[IRQEN_BIT]);

  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_q) && !$past(stat_clr_ovf)) |-> ovf_q);

  // R7
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmo_q) && !$past(stat_clr_tmo)) |-> tmo_q);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !exec_take) |=> (req_valid && $stable(req_word)));

endmodule

// File: tb/nandq_sequencer_tb.sv
`timescale 1ns/1ps
module nandq_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  ce_n;
  logic        cle, ale, we_n, re_n, dq_oe, irq;
  logic [7:0]  dq;
  logic        rb_n = 1'b1;

  always #2.5 clk = ~clk;

  nandq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ce_n_o(ce_n),
    .cle_o(cle), .ale_o(ale), .we_n_o(we_n), .re_n_o(re_n), .dq_o(dq),
    .dq_oe_o(dq_oe), .rb_n_i(rb_n), .irq_o(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bus monitor: one log entry per write strobe.
  int          cyc = 0;
  logic        we_prev = 1'b1;
  int          nlog = 0;
  int          fcur = 0;
  logic [13:0] lg [64];
  int          ft [64];
  int          lw [64];

  always @(negedge clk) begin
    cyc++;
    if (we_prev && !we_n) fcur = cyc;
    if (!we_prev && we_n && nlog < 64) begin
      lg[nlog] = {cle, ale, ce_n, dq};
      ft[nlog] = fcur;
      lw[nlog] = cyc - fcur;
      nlog++;
    end
    we_prev = we_n;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] w_cle(input logic [3:0] c, input logic [7:0] b);
    return (32'h5 << 14) | (32'(c) << 10) | 32'(b);
  endfunction
  function automatic logic [31:0] w_ale(input logic [3:0] c, input logic [7:0] b);
    return (32'h6 << 14) | (32'(c) << 10) | 32'(b);
  endfunction
  function automatic logic [31:0] w_idl(input logic [3:0] c, input int n);
    return (32'hC << 14) | (32'(c) << 10) | (32'(n) & 32'h3FF);
  endfunction
  function automatic logic [31:0] w_rb(input logic [3:0] c, input bit irq_bit, input int e);
    return (32'd1 << 20) | (32'(irq_bit) << 14) | (32'(c) << 10) | (32'(e) & 32'h1F);
  endfunction
  function automatic int len_of(input int f);
    return (f == 0) ? 2 : f + 1;
  endfunction

  task automatic apply_len(input int f);
    wr(2'd1, 32'(f));
    wr(2'd0, 32'h8000_0000);
  endtask

  initial begin : main
    logic [31:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(2'd0, r); chk("R1 occupancy", r, 0);
    rd(2'd1, r); chk("R1 config", r, 32'h5);
    rd(2'd2, r); chk("R1 status", r, 0);
    chk("R1 pins", {ce_n, cle, ale, we_n, re_n, dq_oe, irq}, {4'hF, 6'b001100});
    @(negedge clk);

    // R3 R4 R5 R11: sweep of cycle field 0..7
    for (int f = 0; f < 8; f++) begin
      int L;
      L = len_of(f);
      apply_len(f);
      nlog = 0;
      wr(2'd0, w_cle(4'hE, 8'h80 + 8'(f)));
      wr(2'd0, w_ale(4'hE, 8'h10 + 8'(f)));
      wr(2'd0, w_ale(4'hD, 8'h34));
      wr(2'd0, w_cle(4'hD, 8'h10));
      idle(6 * L + 20);
      chk("R11 byte count", nlog, 4);
      chk("R3 cle byte", lg[0], {2'b10, 4'hE, 8'h80 + 8'(f)});
      chk("R4 ale byte", lg[1], {2'b01, 4'hE, 8'h10 + 8'(f)});
      chk("R4 ale byte ce1", lg[2], {2'b01, 4'hD, 8'h34});
      chk("R11 order last", lg[3], {2'b10, 4'hD, 8'h10});
      for (int i = 0; i < 4; i++) chk("R5 we low width", lw[i], L / 2);
      for (int i = 0; i < 3; i++) chk("R11 byte spacing", ft[i+1] - ft[i], L);
      chk("R12 ce held", ce_n, 4'hD);
    end

    // R5: programmed field without apply keeps old length (L=8)
    wr(2'd1, 32'd2);
    nlog = 0;
    wr(2'd0, w_cle(4'hE, 8'h01));
    idle(30);
    rd(2'd1, r); chk("R5 config readback", r, 2);
    chk("R5 not applied", lw[0], 4);
    wr(2'd0, 32'h8000_0000);
    nlog = 0;
    wr(2'd0, w_cle(4'hE, 8'h02));
    idle(20);
    chk("R5 applied", lw[0], 1);

    // R6: idle sweep at L=3
    for (int n = 0; n < 5; n++) begin
      nlog = 0;
      wr(2'd0, w_ale(4'hE, 8'hA0));
      wr(2'd0, w_idl(4'hE, n));
      wr(2'd0, w_ale(4'hE, 8'hA1));
      idle(40);
      chk("R6 idle gap", ft[1] - ft[0], 3 + ((n == 0) ? 1 : 3 * n));
    end

    // R10: data-move and unknown codes are silent one-clock no-ops
    nlog = 0;
    wr(2'd0, w_ale(4'hD, 8'h55));
    wr(2'd0, (32'd2 << 20) | (32'hE << 10) | 32'h12);
    wr(2'd0, (32'h3 << 14) | (32'hE << 10) | 32'h34);
    wr(2'd0, w_ale(4'hD, 8'h56));
    idle(30);
    chk("R10 strobes", nlog, 2);
    chk("R10 gap", ft[1] - ft[0], 3 + 2);
    chk("R10 ce unchanged", ce_n, 4'hD);
    wr(2'd0, w_idl(4'hE, 0));
    idle(6);
    chk("R12 idle sets ce", ce_n, 4'hE);

    // R9: occupancy excludes request and executing words (L=6)
    apply_len(5);
    nlog = 0;
    for (int i = 0; i < 4; i++) wr(2'd0, w_cle(4'hE, 8'(i)));
    rd(2'd0, r); chk("R9 occupancy", r[26:22], 2);
    idle(40);
    rd(2'd0, r); chk("R9 drained", r[26:22], 0);
    // R9 drain with two idle words
    nlog = 0;
    for (int i = 0; i < 3; i++) wr(2'd0, w_ale(4'hE, 8'h70 + 8'(i)));
    wr(2'd0, w_idl(4'hE, 0));
    wr(2'd0, w_idl(4'hE, 0));
    begin
      int guard = 0;
      rd(2'd0, r);
      while (r[26:22] != 0 && guard < 200) begin
        @(negedge clk); rd(2'd0, r); guard++;
      end
      chk("R9 drain complete", nlog, 3);
    end
    idle(10);

    // R2: overflow with two words held outside the FIFO (L=2)
    apply_len(1);
    wr(2'd0, w_idl(4'hE, 50));
    wr(2'd0, w_idl(4'hE, 50));
    for (int i = 0; i < 9; i++) wr(2'd0, w_idl(4'hE, 1));
    rd(2'd0, r); chk("R2 full occupancy", r[26:22], 8);
    rd(2'd2, r); chk("R2 overflow flag", r[0], 1);
    idle(300);
    rd(2'd0, r); chk("R2 empty after drain", r[26:22], 0);
    rd(2'd2, r); chk("R2 overflow sticky", r[0], 1);
    wr(2'd2, 32'h1);
    rd(2'd2, r); chk("R2 overflow cleared", r[0], 0);
    @(negedge clk);

    // R7: timeout after 2^E bus cycles (L=6)
    apply_len(5);
    rb_n = 1'b0;
    for (int e = 2; e < 5; e++) begin
      int T;
      T = 6 * (1 << e);
      wr(2'd0, w_rb(4'hE, 1'b0, e));
      idle(T - 8);
      rd(2'd2, r); chk("R7 no early timeout", r[1], 0);
      @(negedge clk);
      idle(18);
      rd(2'd2, r); chk("R7 timeout flag", r[1], 1);
      wr(2'd2, 32'h2);
      rd(2'd2, r); chk("R7 timeout cleared", r[1], 0);
      @(negedge clk);
    end

    // R8: interrupt on completion with bit 14 and enable
    wr(2'd1, (32'd1 << 21) | 32'd5);
    wr(2'd0, w_rb(4'hE, 1'b1, 10));
    idle(20);
    chk("R8 irq while busy", irq, 0);
    rb_n = 1'b1;
    idle(8);
    chk("R8 irq raised", irq, 1);
    rd(2'd2, r); chk("R7 no timeout on ready", r[1], 0);
    @(negedge clk);
    idle(5);
    chk("R8 irq held", irq, 1);
    wr(2'd1, 32'd5);
    chk("R8 irq acknowledged", irq, 0);
    // R8 no interrupt without bit 14
    wr(2'd1, (32'd1 << 21) | 32'd5);
    rb_n = 1'b0;
    wr(2'd0, w_rb(4'hE, 1'b0, 10));
    idle(10);
    rb_n = 1'b1;
    idle(10);
    chk("R8 no irq without bit14", irq, 0);
    // R8 no interrupt when enable was clear at completion
    wr(2'd1, 32'd5);
    wr(2'd0, w_rb(4'hE, 1'b1, 10));
    idle(10);
    wr(2'd1, (32'd1 << 21) | 32'd5);
    idle(3);
    chk("R8 no irq when disabled", irq, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule